// File: doc/BRIEF.md
# Frame Injection Word Sequencer

This block takes one outgoing frame at a time from a host-side source and writes it into a switch injection queue as a stream of 32-bit words with separate control writes. A request carries the frame length in bytes and a fixed-size internal header, given as a flat vector. Once the block takes a request, it runs a fixed order of queue cycles. A control write opens the frame. The header words follow, then the payload words, which it pulls one per cycle from the source. Zero words then pad the frame to the minimum size. A second control write closes the frame and states how many bytes of the last word are valid. A zero word follows as a stand-in for the checksum.

The block takes a request only while the queue reports it is ready. It refuses the request at once when the queue is not ready, and also while it is backing off. After each frame it looks at the queue's watermark flag. If the flag is set, the block holds off for a timeout whose length in cycles comes from the clock frequency and a time in nanoseconds. At the end of the timeout it clears the watermark counter if the flag is still set, and then returns to idle.

Top module: `inj_word_seq`

## Requirements
- R1: In idle, a request with `q_rdy` high gives a one-cycle `req_accept`. A request with `q_rdy` low gives `req_refuse` and starts no queue activity.
- R2: The cycle after acceptance is a control write (`q_ctl_wr`) with `q_sof`=1, `q_gap`=1 and no data write.
- R3: The next HDR_WORDS cycles write the header, least significant word of `hdr_in` first. No payload word is read before the last header word.
- R4: Payload takes ceil(len/4) cycles. Each one writes `dat_in` with `dat_rd` high.
- R5: When the payload has fewer than 15 words, zero words follow until header-excluded words total 15. A payload of 15 or more words gets no pad.
- R6: The frame closes with a control write: `q_eof`=1, `q_gap`=1, and `q_vld`=0 for lengths below 60 bytes, else len mod 4.
- R7: The cycle after the closing control write writes exactly one zero word.
- R8: If `q_wmark` is high in the cycle after the zero word, `busy` is high for exactly CLK_MHZ*TIMEOUT_NS/1000 cycles. Requests during that time are refused.
- R9: In the last backoff cycle, `wm_clr` pulses when `q_wmark` is still high and stays low otherwise. The block is idle in the next cycle.
- R10: During reset, all write strobes, `busy`, `wm_clr` and the handshake outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Frame request present |
| req_len | input | LEN_W | Frame length in bytes |
| hdr_in | input | 32*HDR_WORDS | Internal header, word 0 in the low bits |
| req_accept | output | 1 | Request taken this cycle |
| req_refuse | output | 1 | Request refused this cycle |
| dat_in | input | 32 | Current payload word from the source |
| dat_rd | output | 1 | Payload word consumed this cycle |
| q_rdy | input | 1 | Queue ready status |
| q_wmark | input | 1 | Queue watermark reached status |
| q_wr | output | 1 | Data word write strobe |
| q_data | output | 32 | Data word |
| q_ctl_wr | output | 1 | Control write strobe |
| q_sof | output | 1 | Start-of-frame flag on control write |
| q_eof | output | 1 | End-of-frame flag on control write |
| q_gap | output | 2 | Gap size on control write |
| q_vld | output | 2 | Valid bytes in last word on closing control write |
| wm_clr | output | 1 | Watermark counter clear pulse |
| busy | output | 1 | Backoff in progress |

## Verification
The hardest case to reach is the end of a backoff, where the watermark is in one state when the frame finishes and may be in another when the timer expires. The bench raises `q_wmark` in the single cycle after the zero word. It then sets the flag again, or drops it, at the start of the backoff. This covers both outcomes of the clear. A request is also issued in the middle of the backoff window to show the refusal. A length sweep from 0 upward crosses the 60-byte and 15-word boundaries, so that every padding count and every valid-byte code is exercised.

// File: rtl/inj_seq_pkg.sv
package inj_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_SOF, ST_HDR, ST_DATA, ST_PAD, ST_EOF, ST_CRC, ST_CHK, ST_STALL
  } seq_state_e;
  localparam int unsigned MIN_WORDS = 15;
  localparam int unsigned MIN_BYTES = MIN_WORDS * 4;
endpackage

// File: rtl/inj_len_calc.sv
module inj_len_calc
  import inj_seq_pkg::*;
#(
  parameter int unsigned LEN_W = 14
) (
  input  logic [LEN_W-1:0] len,
  output logic [LEN_W-1:0] n_words,
  output logic [3:0]       pad_words,
  output logic [1:0]       vld_bytes
);
  logic [LEN_W:0] rounded;
  logic           short_w;

  always_comb begin
    rounded   = {1'b0, len} + (LEN_W+1)'(3);
    n_words   = {1'b0, rounded[LEN_W:2]};
    short_w   = n_words < LEN_W'(MIN_WORDS);
    pad_words = short_w ? 4'(LEN_W'(MIN_WORDS) - n_words) : 4'd0;
    vld_bytes = (len < LEN_W'(MIN_BYTES)) ? 2'd0 : len[1:0];
  end
endmodule

// File: rtl/inj_backoff_timer.sv
module inj_backoff_timer #(
  parameter int unsigned LOAD  = 12500,
  localparam int unsigned CNT_W = $clog2(LOAD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  output logic expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start || (active && cnt_q != '0);
    cnt_d  = cnt_q;
    if (start)       cnt_d = CNT_W'(LOAD - 1);
    else if (cnt_en) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = active && (cnt_q == '0);
endmodule

// File: rtl/inj_word_seq.sv
module inj_word_seq
  import inj_seq_pkg::*;
#(
  parameter int unsigned LEN_W      = 14,
  parameter int unsigned HDR_WORDS  = 9,
  parameter int unsigned CLK_MHZ    = 250,
  parameter int unsigned TIMEOUT_NS = 50000,
  localparam int unsigned HDR_W     = 32 * HDR_WORDS,
  localparam int unsigned TMO_CYC   = (CLK_MHZ * TIMEOUT_NS / 1000) > 0 ?
                                      (CLK_MHZ * TIMEOUT_NS / 1000) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LEN_W-1:0] req_len,
  input  logic [HDR_W-1:0] hdr_in,
  output logic             req_accept,
  output logic             req_refuse,
  input  logic [31:0]      dat_in,
  output logic             dat_rd,
  input  logic             q_rdy,
  input  logic             q_wmark,
  output logic             q_wr,
  output logic [31:0]      q_data,
  output logic             q_ctl_wr,
  output logic             q_sof,
  output logic             q_eof,
  output logic [1:0]       q_gap,
  output logic [1:0]       q_vld,
  output logic             wm_clr,
  output logic             busy
);
  seq_state_e       st_q, st_d;
  logic [LEN_W-1:0] cnt_q, cnt_d, len_q;
  logic [HDR_W-1:0] hdr_q, hdr_d;
  logic             cnt_en, hdr_en, len_en;
  logic [LEN_W-1:0] n_words;
  logic [3:0]       pad_words;
  logic [1:0]       vld_bytes;
  logic             tmr_start, tmr_done;

  inj_len_calc #(.LEN_W(LEN_W)) u_len (
    .len(len_q), .n_words(n_words), .pad_words(pad_words), .vld_bytes(vld_bytes)
  );

  inj_backoff_timer #(.LOAD(TMO_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(tmr_start),
    .active(st_q == ST_STALL), .expired(tmr_done)
  );

  assign req_accept = (st_q == ST_IDLE) && req_valid && q_rdy;
  assign req_refuse = req_valid &&
                      (((st_q == ST_IDLE) && !q_rdy) || (st_q == ST_STALL));
  assign tmr_start  = (st_q == ST_CHK) && q_wmark;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: if (req_accept) st_d = ST_SOF;
      ST_SOF: begin st_d = ST_HDR; cnt_d = '0; end
      ST_HDR: begin
        if (cnt_q == LEN_W'(HDR_WORDS - 1)) begin
          cnt_d = '0;
          if (n_words != '0)        st_d = ST_DATA;
          else if (pad_words != 0)  st_d = ST_PAD;
          else                      st_d = ST_EOF;
        end else cnt_d = cnt_q + LEN_W'(1);
      end
      ST_DATA: begin
        if (cnt_q == n_words - LEN_W'(1)) begin
          cnt_d = '0;
          st_d  = (pad_words != 0) ? ST_PAD : ST_EOF;
        end else cnt_d = cnt_q + LEN_W'(1);
      end
      ST_PAD: begin
        if (cnt_q == LEN_W'(pad_words) - LEN_W'(1)) begin
          cnt_d = '0;
          st_d  = ST_EOF;
        end else cnt_d = cnt_q + LEN_W'(1);
      end
      ST_EOF:   st_d = ST_CRC;
      ST_CRC:   st_d = ST_CHK;
      ST_CHK:   st_d = q_wmark ? ST_STALL : ST_IDLE;
      ST_STALL: if (tmr_done) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  assign cnt_en = (cnt_d != cnt_q);
  assign len_en = req_accept;
  assign hdr_en = req_accept || (st_q == ST_HDR);
  assign hdr_d  = req_accept ? hdr_in : (hdr_q >> 32);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      len_q <= '0;
      hdr_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (len_en) len_q <= req_len;
      if (hdr_en) hdr_q <= hdr_d;
    end
  end

  always_comb begin
    q_ctl_wr = (st_q == ST_SOF) || (st_q == ST_EOF);
    q_sof    = (st_q == ST_SOF);
    q_eof    = (st_q == ST_EOF);
    q_gap    = q_ctl_wr ? 2'd1 : 2'd0;
    q_vld    = q_eof ? vld_bytes : 2'd0;
    q_wr     = (st_q == ST_HDR) || (st_q == ST_DATA) ||
               (st_q == ST_PAD) || (st_q == ST_CRC);
    dat_rd   = (st_q == ST_DATA);
    q_data   = (st_q == ST_HDR)  ? hdr_q[31:0] :
               (st_q == ST_DATA) ? dat_in : 32'd0;
    busy     = (st_q == ST_STALL);
    wm_clr   = tmr_done && q_wmark;
  end

  assert_refuse_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_refuse |=> (!q_wr && !q_ctl_wr));
  assert_sof_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> (q_ctl_wr && q_sof && q_gap == 2'd1 && !q_wr));
  assert_hdr_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    q_sof |=> (q_wr && !dat_rd));
  assert_crc_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    q_eof |=> (q_wr && q_data == 32'd0 && !q_ctl_wr));
  assert_stall_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(q_wmark) && !$past(q_wr)));
  assert_clr_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wm_clr |=> (!busy && !q_wr && !q_ctl_wr));
endmodule

// File: tb/sim_inj_word_seq.sv
module sim_inj_word_seq;
  localparam int LEN_W = 12, HW = 4, MHZ = 250, TNS = 100;
  localparam int TCYC = MHZ * TNS / 1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, q_rdy = 1'b0, q_wmark = 1'b0;
  logic [LEN_W-1:0] req_len = '0;
  logic [32*HW-1:0] hdr_in = '0;
  logic [31:0] dat_in;
  logic req_accept, req_refuse, dat_rd, q_wr, q_ctl_wr, q_sof, q_eof, wm_clr, busy;
  logic [31:0] q_data;
  logic [1:0] q_gap, q_vld;
  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [15:0] dcnt = '0;
  int cur_len = 0;

  always #2 clk = ~clk;

  inj_word_seq #(.LEN_W(LEN_W), .HDR_WORDS(HW), .CLK_MHZ(MHZ), .TIMEOUT_NS(TNS)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len), .hdr_in(hdr_in),
    .req_accept(req_accept), .req_refuse(req_refuse), .dat_in(dat_in), .dat_rd(dat_rd),
    .q_rdy(q_rdy), .q_wmark(q_wmark), .q_wr(q_wr), .q_data(q_data), .q_ctl_wr(q_ctl_wr),
    .q_sof(q_sof), .q_eof(q_eof), .q_gap(q_gap), .q_vld(q_vld), .wm_clr(wm_clr), .busy(busy));

  assign dat_in = {16'(cur_len), dcnt} ^ 32'h5A5A_0000;
  always @(posedge clk) if (dat_rd) dcnt <= dcnt + 16'd1;

  function automatic logic [9:0] ctl_vec(logic wr, logic cw, logic s, logic e,
                                         logic [1:0] g, logic [1:0] v, logic rd, logic b);
    return {wr, cw, s, e, g, v, rd, b};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog R10 actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  function automatic logic [9:0] now_vec();
    return ctl_vec(q_wr, q_ctl_wr, q_sof, q_eof, q_gap, q_vld, dat_rd, busy);
  endfunction

  task automatic do_frame(int len, bit wm_after, bit wm_end);
    int n, pad, vld;
    logic [15:0] base;
    n   = (len + 3) / 4;
    pad = (n < 15) ? 15 - n : 0;
    vld = (len < 60) ? 0 : len % 4;
    @(negedge clk);
    cur_len = len; base = dcnt;
    req_len = LEN_W'(len); q_rdy = 1'b1; req_valid = 1'b1;
    for (int i = 0; i < HW; i++) hdr_in[32*i +: 32] = 32'hC0DE_0000 | (len << 4) | i;
    #1 chk("R1 accept", {req_accept, req_refuse}, 2'b10);
    @(negedge clk); req_valid = 1'b0;
    chk("R2 sof ctl", now_vec(), ctl_vec(0,1,1,0,2'd1,2'd0,0,0));
    for (int i = 0; i < HW; i++) begin
      @(negedge clk);
      chk("R3 hdr ctl", now_vec(), ctl_vec(1,0,0,0,2'd0,2'd0,0,0));
      chk("R3 hdr word", q_data, 32'hC0DE_0000 | (len << 4) | i);
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R4 data ctl", now_vec(), ctl_vec(1,0,0,0,2'd0,2'd0,1,0));
      chk("R4 data word", q_data, {16'(len), 16'(base + 16'(i))} ^ 32'h5A5A_0000);
    end
    for (int i = 0; i < pad; i++) begin
      @(negedge clk);
      chk("R5 pad ctl", now_vec(), ctl_vec(1,0,0,0,2'd0,2'd0,0,0));
      chk("R5 pad word", q_data, 32'd0);
    end
    @(negedge clk);
    chk("R6 eof ctl", now_vec(), ctl_vec(0,1,0,1,2'd1,2'(vld),0,0));
    @(negedge clk);
    chk("R7 crc ctl", now_vec(), ctl_vec(1,0,0,0,2'd0,2'd0,0,0));
    chk("R7 crc word", q_data, 32'd0);
    @(negedge clk);
    q_wmark = wm_after;
    @(negedge clk);
    if (wm_after) begin
      q_wmark = wm_end;
      for (int i = 0; i < TCYC; i++) begin
        req_valid = (i == 3);
        #1;
        chk("R8 busy", {busy, q_wr, q_ctl_wr}, 3'b100);
        chk("R9 clr", wm_clr, (i == TCYC - 1) && wm_end);
        if (i == 3) chk("R8 refuse", {req_accept, req_refuse}, 2'b01);
        @(negedge clk);
      end
      req_valid = 1'b0;
    end
    chk("R9 idle after", {busy, wm_clr, q_wr, q_ctl_wr}, 4'b0000);
    q_wmark = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset", {now_vec(), wm_clr, req_accept, req_refuse}, 13'd0);
    rst_n = 1'b1;
    @(negedge clk);
    q_rdy = 1'b0; req_valid = 1'b1; req_len = 12'd40;
    #1 chk("R1 refuse", {req_accept, req_refuse}, 2'b01);
    @(negedge clk);
    chk("R1 no start", {q_wr, q_ctl_wr}, 2'b00);
    req_valid = 1'b0;
    for (int l = 0; l <= 70; l++) do_frame(l, 1'b0, 1'b0);
    do_frame(255, 1'b0, 1'b0);
    do_frame(1023, 1'b0, 1'b0);
    do_frame(20, 1'b1, 1'b1);
    do_frame(64, 1'b1, 1'b0);
    do_frame(61, 1'b0, 1'b0);
    finish_run();
  end
endmodule